// File: doc/BRIEF.md
# Two-Channel Line Transfer Engine for a 16-bit Image Bus

This block moves scan lines between peripheral devices and image memory over a shared 16-bit image bus. Channel 0 fetches words from an input device, such as a scanner, and writes them into memory. Channel 1 reads words from memory and hands them to an output device, such as a printer. Each channel has a base address and a line length counted in 16-bit words. Software loads both values with a one-clock arm pulse.

An armed channel raises its start output. The device then asserts its request input. For each word, the engine asks for the bus and waits for the grant. It then runs two bus cycles: a read from the source and a write to the sink. Each cycle is stretched until the ready input is sampled high. During the device-side cycle, the engine acknowledges the device. The address moves up by one word per transfer. After the last word, a one-clock completion pulse is issued and the start output stays low until the next arm.

The bus request is dropped after every word, and the two channels then take turns. Pad tri-stating is done outside this block under the `bus_oe` enable. Whenever `bus_oe` is low, the address, data enable and all strobes are held at zero.

Top module: `imgbus_line_dma`

## Requirements
- R1: After reset, `bus_req`, `bus_oe`, `data_oe`, every strobe, `dev_start`, `dev_ack` and `line_done` are all low.
- R2: A pulse on `arm[c]` loads `base_c`/`len_c` (len ≥ 1) into channel c and raises `dev_start[c]`, which stays high until that line completes.
- R3: `bus_req` rises when an armed channel has its `dev_req` high; no strobe, address or `bus_oe` is driven while `bus_gnt` is low, and `bus_oe` is never high without `bus_gnt`.
- R4: For channel 0, each word is an `io_rd` cycle whose `data_i` is captured, then an `mem_wr` cycle driving that word on `data_o` with `data_oe` high; `ube` and `lbe` are both high during every memory strobe.
- R5: For channel 1, each word is a `mem_rd` cycle whose `data_i` is captured, then an `io_wr` cycle driving that word on `data_o`.
- R6: At most one strobe is active at a time, and an active strobe stays active until `rdy` is sampled high, for any number of wait cycles.
- R7: The memory address of word k of a line is base + k.
- R8: After exactly `len` words, `line_done[c]` is high for one clock and `dev_start[c]` is low from then until the next arm.
- R9: When both channels are pending at once, the channel that was not served by the previous word goes first; after reset, channel 0 goes first. With both pending continuously, the words alternate 0,1,0,1.
- R10: `dev_ack[c]` is high exactly during the device-side strobe (`io_rd` for channel 0, `io_wr` for channel 1) of channel c.
- R11: `bus_req` is low in the cycle after the write cycle of each word completes.
- R12: `dev_req[c]` has no effect while channel c is not armed: `bus_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 2 | One-clock load pulse per channel |
| base_0 | input | 16 | Channel 0 start word address |
| len_0 | input | 13 | Channel 0 line length in words |
| base_1 | input | 16 | Channel 1 start word address |
| len_1 | input | 13 | Channel 1 line length in words |
| dev_start | output | 2 | Channel armed and ready for its device |
| dev_req | input | 2 | Device transfer request |
| dev_ack | output | 2 | Device acknowledge during its strobe |
| line_done | output | 2 | One-clock pulse at end of line |
| bus_req | output | 1 | Image bus ownership request |
| bus_gnt | input | 1 | Image bus grant |
| rdy | input | 1 | Ends the current bus cycle |
| bus_oe | output | 1 | Pad drive enable for address and strobes |
| addr_o | output | 16 | Memory word address |
| data_i | input | 16 | Read data from bus |
| data_o | output | 16 | Write data to bus |
| data_oe | output | 1 | Data pad drive enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| ube | output | 1 | Upper byte enable |
| lbe | output | 1 | Lower byte enable |

## Verification
The bench withholds the grant while a request is pending. A design that drove strobes early would write memory without owning the bus. Lines run with zero to two wait states, and a design that dropped a strobe before `rdy` would lose or duplicate words in the bench's memory and printer models. Both channels are armed together after a reset to check the 0,1,0,1 word order: a fixed-priority design would finish channel 0 first and starve channel 1. The bench also checks that `dev_req` on an unarmed channel leaves the bus alone, and that the completion pulse lasts exactly one clock. A design with a wrong length count would miss that pulse or produce a second one.

// File: rtl/imgdma_pkg.sv
package imgdma_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_SRC  = 2'd2,
    S_DST  = 2'd3
  } dma_st_t;

  localparam int NCH = 2;
endpackage

// File: rtl/imgdma_arb.sv
module imgdma_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pend,
  input  logic       adv,
  input  logic       served,
  output logic       any,
  output logic       pick
);
  logic last_q, last_d;

  always_comb begin
    any  = |pend;
    pick = (pend == 2'b11) ? ~last_q : pend[1];
  end

  always_comb begin
    last_d = last_q;
    if (adv) last_d = served;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= last_d;
  end

  p_pick_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> pend[pick]);
endmodule

// File: rtl/imgdma_chan.sv
module imgdma_chan #(
  parameter int AW = 16,
  parameter int LW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          armed,
  output logic          done
);
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] left_q, left_d;
  logic          armed_q, armed_d;
  logic          done_q, done_d;

  always_comb begin
    addr_d  = addr_q;
    left_d  = left_q;
    armed_d = armed_q;
    done_d  = 1'b0;
    if (arm) begin
      addr_d  = base;
      left_d  = len;
      armed_d = 1'b1;
    end else if (step) begin
      addr_d = addr_q + AW'(1);
      left_d = left_q - LW'(1);
      if (left_q == LW'(1)) begin
        armed_d = 1'b0;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      left_q  <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      left_q  <= left_d;
      armed_q <= armed_d;
      done_q  <= done_d;
    end
  end

  assign addr  = addr_q;
  assign armed = armed_q;
  assign done  = done_q;

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !armed);
  p_step_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> armed);
endmodule

// File: rtl/imgbus_line_dma.sv
module imgbus_line_dma #(
  parameter int AW = 16,
  parameter int LW = 13,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    arm,
  input  logic [AW-1:0] base_0,
  input  logic [LW-1:0] len_0,
  input  logic [AW-1:0] base_1,
  input  logic [LW-1:0] len_1,
  output logic [1:0]    dev_start,
  input  logic [1:0]    dev_req,
  output logic [1:0]    dev_ack,
  output logic [1:0]    line_done,
  output logic          bus_req,
  input  logic          bus_gnt,
  input  logic          rdy,
  output logic          bus_oe,
  output logic [AW-1:0] addr_o,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          io_rd,
  output logic          io_wr,
  output logic          ube,
  output logic          lbe
);
  import imgdma_pkg::*;

  logic [AW-1:0] ch_addr [NCH];
  logic [AW-1:0] ch_base [NCH];
  logic [LW-1:0] ch_len  [NCH];
  logic [NCH-1:0] armed, done, step, pend;

  dma_st_t       st_q, st_d;
  logic          sel_q, sel_d;
  logic [DW-1:0] buf_q, buf_d;
  logic          any, pick, adv, act;

  assign ch_base[0] = base_0;
  assign ch_base[1] = base_1;
  assign ch_len[0]  = len_0;
  assign ch_len[1]  = len_1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    imgdma_chan #(.AW(AW), .LW(LW)) u_chan (
      .clk(clk), .rst_n(rst_n), .arm(arm[c]),
      .base(ch_base[c]), .len(ch_len[c]), .step(step[c]),
      .addr(ch_addr[c]), .armed(armed[c]), .done(done[c])
    );
  end

  assign pend = armed & dev_req;

  imgdma_arb u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .adv(adv),
    .served(sel_q), .any(any), .pick(pick)
  );

  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    buf_d = buf_q;
    adv   = 1'b0;
    step  = '0;
    unique case (st_q)
      S_IDLE: if (any) begin
        st_d  = S_REQ;
        sel_d = pick;
      end
      S_REQ: if (bus_gnt) st_d = S_SRC;
      S_SRC: if (bus_gnt && rdy) begin
        st_d  = S_DST;
        buf_d = data_i;
      end
      S_DST: if (bus_gnt && rdy) begin
        st_d        = S_IDLE;
        adv         = 1'b1;
        step[sel_q] = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      sel_q <= 1'b0;
      buf_q <= '0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
      buf_q <= buf_d;
    end
  end

  always_comb begin
    act     = bus_gnt && (st_q == S_SRC || st_q == S_DST);
    bus_oe  = act;
    bus_req = (st_q != S_IDLE);
    io_rd   = act && st_q == S_SRC && !sel_q;
    mem_rd  = act && st_q == S_SRC &&  sel_q;
    mem_wr  = act && st_q == S_DST && !sel_q;
    io_wr   = act && st_q == S_DST &&  sel_q;
    ube     = mem_rd || mem_wr;
    lbe     = mem_rd || mem_wr;
    data_oe = act && st_q == S_DST;
    data_o  = buf_q;
    addr_o  = act ? ch_addr[sel_q] : '0;
    dev_ack = {io_wr && sel_q, io_rd && !sel_q};
    dev_start = armed;
    line_done = done;
  end

  p_oe_gnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> bus_gnt);
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr}));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr || io_rd || io_wr) && !rdy)
      |=> (!bus_gnt || {mem_rd, mem_wr, io_rd, io_wr} == $past({mem_rd, mem_wr, io_rd, io_wr})));
  p_ack_armed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack & ~dev_start) == 2'b00);
  p_req_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|step) |=> !bus_req);
endmodule

// File: tb/tb_imgbus_line_dma.sv
`timescale 1ns/1ps
module tb_imgbus_line_dma;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  arm, dev_req, dev_start, dev_ack, line_done;
  logic [15:0] base_0, base_1, addr_o, data_i, data_o;
  logic [12:0] len_0, len_1;
  logic        bus_req, bus_gnt, rdy, bus_oe, data_oe;
  logic        mem_rd, mem_wr, io_rd, io_wr, ube, lbe;

  always #4 clk = ~clk;

  imgbus_line_dma dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .base_0(base_0), .len_0(len_0),
    .base_1(base_1), .len_1(len_1), .dev_start(dev_start), .dev_req(dev_req),
    .dev_ack(dev_ack), .line_done(line_done), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .rdy(rdy), .bus_oe(bus_oe), .addr_o(addr_o), .data_i(data_i), .data_o(data_o),
    .data_oe(data_oe), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .ube(ube), .lbe(lbe)
  );

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench models of memory, scanner and printer
  logic [15:0] mem [64];
  logic [15:0] prn [64];
  int scan_idx, prn_idx, waits, wcnt, mword [2], xbase [2], done_cyc [2];
  int order [8];
  int n_order;
  bit gnt_en, was_wait, after_dst;
  logic [3:0] prev_strb;

  function automatic logic [15:0] scan_val(input int k);
    return 16'h5A00 + 16'(k * 3);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (after_dst) chk(!bus_req, "R11 bus_req low after word", bus_req, 0);
      after_dst = 1'b0;
      if (was_wait)
        chk({mem_rd, mem_wr, io_rd, io_wr} == prev_strb, "R6 strobe held",
            {mem_rd, mem_wr, io_rd, io_wr}, prev_strb);
      was_wait = 1'b0;
      for (int c = 0; c < 2; c++) if (line_done[c]) done_cyc[c]++;
      rdy = 1'b0;
      if (mem_rd || mem_wr || io_rd || io_wr) begin
        if (mem_rd || mem_wr) chk(ube && lbe, "R4 byte enables", {ube, lbe}, 3);
        if (io_rd) chk(dev_ack == 2'b01, "R10 ack ch0", dev_ack, 1);
        if (io_wr) chk(dev_ack == 2'b10, "R10 ack ch1", dev_ack, 2);
        if (mem_rd || mem_wr) chk(dev_ack == 2'b00, "R10 no ack on memory", dev_ack, 0);
        if (wcnt >= waits) begin
          wcnt = 0;
          rdy  = 1'b1;
          if (io_rd) begin
            data_i = scan_val(scan_idx); scan_idx++;
            order[n_order % 8] = 0; n_order++;
          end
          if (mem_rd) begin
            chk(addr_o == 16'(xbase[1] + mword[1]), "R7 ch1 address", addr_o, xbase[1] + mword[1]);
            mword[1]++;
            data_i = mem[addr_o[5:0]];
            order[n_order % 8] = 1; n_order++;
          end
          if (mem_wr) begin
            chk(data_oe, "R4 data_oe on write", data_oe, 1);
            chk(addr_o == 16'(xbase[0] + mword[0]), "R7 ch0 address", addr_o, xbase[0] + mword[0]);
            mword[0]++;
            mem[addr_o[5:0]] = data_o;
            after_dst = 1'b1;
          end
          if (io_wr) begin
            chk(data_oe, "R5 data_oe on write", data_oe, 1);
            prn[prn_idx % 64] = data_o; prn_idx++;
            after_dst = 1'b1;
          end
        end else begin
          wcnt++;
          was_wait  = 1'b1;
          prev_strb = {mem_rd, mem_wr, io_rd, io_wr};
        end
      end
      bus_gnt = bus_req && gnt_en;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic clr_model();
    scan_idx = 0; prn_idx = 0; wcnt = 0; n_order = 0;
    mword[0] = 0; mword[1] = 0; done_cyc[0] = 0; done_cyc[1] = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; arm = '0; dev_req = '0; rdy = 1'b0; bus_gnt = 1'b0;
    data_i = '0; base_0 = '0; base_1 = '0; len_0 = '0; len_1 = '0;
    was_wait = 1'b0; after_dst = 1'b0; gnt_en = 1'b1; waits = 0;
    clr_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic arm_ch(input int ch, input int base, input int len);
    xbase[ch] = base; mword[ch] = 0;
    if (ch == 0) begin base_0 = 16'(base); len_0 = 13'(len); end
    else         begin base_1 = 16'(base); len_1 = 13'(len); end
    arm[ch] = 1'b1;
    @(negedge clk);
    arm = '0;
  endtask

  task automatic wait_done(input int ch);
    for (int i = 0; i < 3000 && done_cyc[ch] == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic       ch;
    logic [7:0] base;
    logic [7:0] len;
    logic [3:0] wt;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 8'd4,  8'd3, 4'd0},
    '{1'b1, 8'd4,  8'd3, 4'd1},
    '{1'b0, 8'd20, 8'd5, 4'd2},
    '{1'b1, 8'd20, 8'd5, 4'd0},
    '{1'b1, 8'd33, 8'd1, 4'd2}
  };

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'hC000 + 16'(i);
    do_reset();

    // R1 reset state
    chk({bus_req, bus_oe, data_oe, mem_rd, mem_wr, io_rd, io_wr} == 0, "R1 bus idle",
        {bus_req, bus_oe, data_oe, mem_rd, mem_wr, io_rd, io_wr}, 0);
    chk({dev_start, dev_ack, line_done} == 0, "R1 channel outputs",
        {dev_start, dev_ack, line_done}, 0);

    // R12 request on unarmed channel ignored
    dev_req = 2'b11;
    repeat (10) @(negedge clk);
    chk(!bus_req, "R12 unarmed request ignored", bus_req, 0);
    chk(!bus_oe, "R12 no bus drive", bus_oe, 0);
    dev_req = 2'b00;

    // table of line transfers
    for (int v = 0; v < 5; v++) begin
      automatic int ch = int'(VECS[v].ch);
      automatic int b  = int'(VECS[v].base);
      automatic int l  = int'(VECS[v].len);
      automatic logic [15:0] snap [64];
      for (int i = 0; i < 64; i++) snap[i] = mem[i];
      clr_model();
      waits = int'(VECS[v].wt);
      arm_ch(ch, b, l);
      chk(dev_start[ch], "R2 start after arm", dev_start, 1 << ch);
      dev_req[ch] = 1'b1;
      wait_done(ch);
      dev_req = '0;
      chk(done_cyc[ch] == 1, "R8 one-clock done pulse", done_cyc[ch], 1);
      chk(!dev_start[ch], "R8 start low after line", dev_start[ch], 0);
      if (ch == 0) begin
        chk(mword[0] == l, "R4 words written", mword[0], l);
        for (int k = 0; k < l; k++)
          chk(mem[b + k] == scan_val(k), "R4 scanned data in memory", mem[b + k], scan_val(k));
      end else begin
        chk(prn_idx == l, "R5 words printed", prn_idx, l);
        for (int k = 0; k < l; k++)
          chk(prn[k] == snap[b + k], "R5 memory data to printer", prn[k], snap[b + k]);
      end
    end

    // R8 start stays low until re-arm, even with request held
    dev_req = 2'b01;
    repeat (8) @(negedge clk);
    chk(!bus_req && !dev_start[0], "R8 no transfer before re-arm", {bus_req, dev_start[0]}, 0);
    dev_req = '0;

    // R3 grant withheld
    clr_model(); waits = 0;
    gnt_en = 1'b0;
    arm_ch(0, 50, 1);
    dev_req = 2'b01;
    repeat (6) @(negedge clk);
    chk(bus_req, "R3 request raised", bus_req, 1);
    chk(!bus_oe && !io_rd && !mem_wr && addr_o == 0, "R3 nothing driven without grant",
        {bus_oe, io_rd, mem_wr}, 0);
    chk(mword[0] == 0, "R3 no write without grant", mword[0], 0);
    gnt_en = 1'b1;
    wait_done(0);
    dev_req = '0;
    chk(mem[50] == scan_val(0), "R3 word after grant", mem[50], scan_val(0));

    // R9 rotation after reset
    do_reset();
    base_0 = 16'd40; len_0 = 13'd2; base_1 = 16'd56; len_1 = 13'd2;
    xbase[0] = 40; xbase[1] = 56;
    arm = 2'b11;
    @(negedge clk);
    arm = '0;
    dev_req = 2'b11;
    wait_done(1);
    wait_done(0);
    dev_req = '0;
    chk(n_order == 4, "R9 four words", n_order, 4);
    for (int k = 0; k < 4; k++)
      chk(order[k] == (k % 2), "R9 alternating order", order[k], k % 2);
    chk(done_cyc[0] == 1 && done_cyc[1] == 1, "R8 both lines done", {done_cyc[0], done_cyc[1]}, 'h11);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule